// File: doc/BRIEF.md
# Tagged Fan-In / Fan-Out Pipeline

This block merges operand streams from several independent requesters into one shared multi-stage pipeline and sends each result back to the requester that produced it. Every input port carries a pair of operands under its own valid/ready handshake. A round-robin arbiter picks one requesting port per cycle. The index of the winning port is stored next to the operands as a routing tag. The tag moves through every stage without change. At the exit, the tag selects the one output port that presents the result.

The payload operation is a fixed-latency placeholder: the two operands are added as unsigned integers and the sum is truncated to the operand width. Each pipeline stage holds a valid bit. A stage takes new data when it is empty or when its content moves on in the same cycle, so bubbles close up. If the addressed output port is not ready, the last stage holds its result. The stall spreads upstream only as far as there are no empty stages left to absorb it. When every stage is full and stalled, all input ready signals drop.

Back-pressure rules, for both directions: a transfer happens on a clock edge where valid and ready are both high. The sender keeps valid and data steady until that edge. An input ready may depend combinationally on the valid inputs (through the arbiter) and on the output ready signals. No output valid depends on any ready.

Top module: `tagged_pipe_fan`

## Requirements
- R1: An input transfer occurs only on an edge where `in_valid[p]` and `in_ready[p]` are both high, and at most one bit of `in_ready` is high in any cycle.
- R2: Arbitration is round-robin. After port p is accepted, the search for the next winner starts at port p+1 and wraps from port NUM_PORTS-1 to port 0. After reset the search starts at port 0. The lowest search position whose valid is high wins.
- R3: The tag stored with a transfer is the index of the accepting input port. It reaches the output unchanged, and `out_tag` of port q reads q whenever `out_valid[q]` is high.
- R4: A result is presented only on the output port whose index equals its tag, so at most one bit of `out_valid` is high in any cycle.
- R5: The result equals `(a + b) mod 2**DATA_W`. Operand a sits in `in_a[p*DATA_W +: DATA_W]` and operand b in `in_b[p*DATA_W +: DATA_W]`. The result for port q appears in `out_sum[q*DATA_W +: DATA_W]`.
- R6: With no stall, a result is valid at the output after the accepting edge plus NUM_STAGES-1 further edges.
- R7: While `out_valid[q]` is high and `out_ready[q]` is low, the next cycle still shows `out_valid[q]` high with the same `out_sum` and `out_tag`.
- R8: When every stage holds data and the addressed output is not ready, every bit of `in_ready` is low.
- R9: Per port, results leave in the order the operands were accepted. Idle gaps on the inputs lose or duplicate nothing.
- R10: Reset (active-low `rst_n`, asynchronous) empties all stages, clears every `out_valid`, and points the arbiter at port 0.
- R11: A stage accepts new data whenever it is empty or its content moves on in the same cycle. A stall at the exit therefore still lets inputs in while an empty stage remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_PORTS | Per-port operand valid |
| in_ready | output | NUM_PORTS | Per-port operand ready |
| in_a | input | NUM_PORTS*DATA_W | Operand a, port p at bits p*DATA_W |
| in_b | input | NUM_PORTS*DATA_W | Operand b, port p at bits p*DATA_W |
| out_valid | output | NUM_PORTS | Per-port result valid |
| out_ready | input | NUM_PORTS | Per-port result ready |
| out_sum | output | NUM_PORTS*DATA_W | Result, port q at bits q*DATA_W |
| out_tag | output | NUM_PORTS*TAG_W | Carried source index, port q at bits q*TAG_W |

## Verification
The bench builds the block with its defaults: four ports, 32-bit operands and three stages. Four ports make the arbiter pointer wrap from port 3 back to port 0. Three stages are deep enough to show three separate cases: a stalled exit whose bubble is absorbed upstream, a full pipe that shuts every input, and a result that lands two edges after acceptance. The 32-bit operands are random and reach carry-out truncation. Operand valids use random gaps and output readies are random, so the per-port order checks run under every mix of stall and idle.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  function automatic int tag_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tpf_rr_arbiter.sv
module tpf_rr_arbiter #(
  parameter int NUM_PORTS = 4,
  parameter int TAG_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req,
  input  logic                 take,
  output logic                 gnt_any,
  output logic [TAG_W-1:0]     gnt_idx
);
  logic [TAG_W-1:0] ptr;

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = NUM_PORTS - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr) + k) % NUM_PORTS;
      if (req[j]) begin
        gnt_any = 1'b1;
        gnt_idx = TAG_W'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (take) ptr <= (int'(gnt_idx) == NUM_PORTS - 1) ? '0 : gnt_idx + 1'b1;
  end

  AST_GRANT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any |-> req[gnt_idx]); // R2
  AST_NO_REPEAT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && $past(take) && gnt_idx == $past(gnt_idx)) |-> $countones(req) == 1); // R2
endmodule

// File: rtl/tpf_stage.sv
module tpf_stage #(
  parameter int PAY_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_v,
  input  logic [PAY_W-1:0] up_d,
  output logic             up_go,
  output logic             dn_v,
  output logic [PAY_W-1:0] dn_d,
  input  logic             dn_go
);
  assign up_go = !dn_v || dn_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dn_v <= 1'b0;
    else if (up_go) dn_v <= up_v;
  end

  always_ff @(posedge clk) begin
    if (up_go && up_v) dn_d <= up_d;
  end

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_v && !dn_go) |=> (dn_v && $stable(dn_d))); // R11
endmodule

// File: rtl/tpf_router.sv
module tpf_router #(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           res_v,
  input  logic [DATA_W-1:0]              res_sum,
  input  logic [TAG_W-1:0]               res_tag,
  output logic                           res_go,
  output logic [NUM_PORTS-1:0]           out_valid,
  input  logic [NUM_PORTS-1:0]           out_ready,
  output logic [NUM_PORTS*DATA_W-1:0]    out_sum,
  output logic [NUM_PORTS*TAG_W-1:0]     out_tag
);
  assign res_go = !res_v || out_ready[res_tag];

  for (genvar q = 0; q < NUM_PORTS; q++) begin : g_port
    assign out_valid[q]                   = res_v && (int'(res_tag) == q);
    assign out_sum[q*DATA_W +: DATA_W]    = res_sum;
    assign out_tag[q*TAG_W +: TAG_W]      = res_tag;

    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[q] |-> (int'(out_tag[q*TAG_W +: TAG_W]) == q)); // R3
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[q] && !out_ready[q]) |=>
        (out_valid[q] && $stable(out_sum[q*DATA_W +: DATA_W]))); // R7
  end
endmodule

// File: rtl/tagged_pipe_fan.sv
module tagged_pipe_fan
  import tpf_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 3,
  parameter int TAG_W      = tag_bits(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS-1:0]        in_valid,
  output logic [NUM_PORTS-1:0]        in_ready,
  input  logic [NUM_PORTS*DATA_W-1:0] in_a,
  input  logic [NUM_PORTS*DATA_W-1:0] in_b,
  output logic [NUM_PORTS-1:0]        out_valid,
  input  logic [NUM_PORTS-1:0]        out_ready,
  output logic [NUM_PORTS*DATA_W-1:0] out_sum,
  output logic [NUM_PORTS*TAG_W-1:0]  out_tag
);
  localparam int PAY_W = DATA_W + TAG_W;

  logic                 gnt_any;
  logic [TAG_W-1:0]     gnt_idx;
  logic                 take;
  logic [DATA_W-1:0]    sel_a, sel_b;

  logic [NUM_STAGES:0]  st_v;
  logic [PAY_W-1:0]     st_d [NUM_STAGES+1];
  logic [NUM_STAGES:0]  st_go;

  tpf_rr_arbiter #(.NUM_PORTS(NUM_PORTS), .TAG_W(TAG_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(in_valid), .take(take),
    .gnt_any(gnt_any), .gnt_idx(gnt_idx)
  );

  assign sel_a = in_a[gnt_idx*DATA_W +: DATA_W];
  assign sel_b = in_b[gnt_idx*DATA_W +: DATA_W];
  assign take  = gnt_any && st_go[0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rdy
    assign in_ready[p] = take && (int'(gnt_idx) == p);
  end

  assign st_v[0] = gnt_any;
  assign st_d[0] = {gnt_idx, sel_a + sel_b};

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    tpf_stage #(.PAY_W(PAY_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .up_v(st_v[k]), .up_d(st_d[k]), .up_go(st_go[k]),
      .dn_v(st_v[k+1]), .dn_d(st_d[k+1]), .dn_go(st_go[k+1])
    );
  end

  tpf_router #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rt (
    .clk(clk), .rst_n(rst_n),
    .res_v(st_v[NUM_STAGES]),
    .res_sum(st_d[NUM_STAGES][DATA_W-1:0]),
    .res_tag(st_d[NUM_STAGES][PAY_W-1:DATA_W]),
    .res_go(st_go[NUM_STAGES]),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_tag(out_tag)
  );

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready)); // R1
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0); // R1
  AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid)); // R4
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (&st_v[NUM_STAGES:1] && (out_valid & out_ready) == '0) |-> in_ready == '0); // R8
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> out_valid == '0); // R10
endmodule

// File: tb/sim_tagged_pipe_fan.sv
`timescale 1ns/1ps
module sim_tagged_pipe_fan;
  localparam int NP = 4;
  localparam int DW = 32;
  localparam int NS = 3;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] in_valid = '0, in_ready, out_valid, out_ready = '0;
  logic [NP*DW-1:0] in_a = '0, in_b = '0, out_sum;
  logic [NP*TW-1:0] out_tag;

  always #2.5 clk = ~clk;

  tagged_pipe_fan #(.NUM_PORTS(NP), .DATA_W(DW), .NUM_STAGES(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum), .out_tag(out_tag)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference state: in-flight slots, oldest at the exit end
  bit          ref_full [NS];
  logic [31:0] ref_sum  [NS];
  int          ref_dst  [NS];
  int          rr_next = 0;
  logic [31:0] pend [NP][$];
  bit          want [NP];
  logic [31:0] va [NP], vb [NP];
  logic [NP-1:0] rdy_pat;
  bit          was_stalled = 0;

  task automatic cycle(input int vpct, input int rpct);
    bit slot_go [NS+1];
    int winner;
    bit exit_stall, full;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      if (!want[p] && ($urandom_range(99) < vpct)) begin
        want[p] = 1; va[p] = $urandom(); vb[p] = $urandom();
      end
      in_valid[p] = want[p];
      in_a[p*DW +: DW] = va[p];
      in_b[p*DW +: DW] = vb[p];
      out_ready[p] = ($urandom_range(99) < rpct);
    end
    #1;
    // exit can move if empty or the addressed port takes it
    slot_go[NS] = !ref_full[NS-1] || out_ready[ref_dst[NS-1]];
    for (int k = NS - 1; k >= 0; k--)
      slot_go[k] = (k == 0) ? (!ref_full[0] || slot_go[1]) : (!ref_full[k] || slot_go[k+1]);
    // slot_go[k] : slot k may load (k==0 is the entry slot)
    winner = -1;
    for (int k = 0; k < NP; k++) begin
      int j;
      j = (rr_next + k) % NP;
      if (winner < 0 && want[j]) winner = j;
    end
    exit_stall = ref_full[NS-1] && !out_ready[ref_dst[NS-1]];
    full = 1;
    for (int k = 0; k < NS; k++) full &= ref_full[k];
    chk($countones(in_ready) <= 1, "R1", in_ready, 0);
    for (int p = 0; p < NP; p++) begin
      bit er;
      er = slot_go[0] && (winner == p);
      if (exit_stall && full) chk(in_ready[p] == 1'b0, "R8", in_ready[p], 0);
      else if (exit_stall) chk(in_ready[p] == er, "R11", in_ready[p], er);
      else chk(in_ready[p] == er, "R2", in_ready[p], er);
    end
    for (int q = 0; q < NP; q++) begin
      bit ev;
      ev = ref_full[NS-1] && ref_dst[NS-1] == q;
      chk(out_valid[q] == ev, "R4/R6", out_valid[q], ev);
      if (ev && out_valid[q]) begin
        chk(out_sum[q*DW +: DW] == ref_sum[NS-1], was_stalled ? "R7" : "R5",
            out_sum[q*DW +: DW], ref_sum[NS-1]);
        chk(int'(out_tag[q*TW +: TW]) == q, "R3", out_tag[q*TW +: TW], q);
        chk(pend[q].size() > 0 && pend[q][0] == out_sum[q*DW +: DW], "R9",
            out_sum[q*DW +: DW], (pend[q].size() > 0) ? pend[q][0] : 32'hx);
      end
    end
    was_stalled = exit_stall;
    @(posedge clk);
    if (ref_full[NS-1] && out_ready[ref_dst[NS-1]] && pend[ref_dst[NS-1]].size() > 0)
      void'(pend[ref_dst[NS-1]].pop_front());
    for (int k = NS - 1; k >= 1; k--)
      if (slot_go[k+1] || !ref_full[k]) begin
        if (slot_go[k]) begin
          ref_full[k] = ref_full[k-1];
          ref_sum[k] = ref_sum[k-1];
          ref_dst[k] = ref_dst[k-1];
        end
      end
    if (slot_go[0]) begin
      ref_full[0] = (winner >= 0);
      if (winner >= 0) begin
        ref_sum[0] = va[winner] + vb[winner];
        ref_dst[0] = winner;
        pend[winner].push_back(va[winner] + vb[winner]);
        want[winner] = 0;
        rr_next = (winner + 1) % NP;
      end
    end
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin ref_full[k] = 0; ref_sum[k] = 0; ref_dst[k] = 0; end
    for (int p = 0; p < NP; p++) begin want[p] = 0; va[p] = 0; vb[p] = 0; end
    repeat (4) @(posedge clk);
    #1;
    chk(out_valid == '0, "R10", out_valid, 0);
    chk(in_ready == '0, "R10", in_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 R6: all ports busy, sink always ready
    repeat (40) cycle(100, 100);
    // R9: idle gaps on inputs, sink ready
    repeat (200) cycle(30, 100);
    // R7 R8 R11: sink stalls often
    repeat (400) cycle(70, 30);
    // R8: sink closed while inputs push
    repeat (20) cycle(100, 0);
    // mixed pressure
    repeat (2000) cycle($urandom_range(100), $urandom_range(100));
    // drain
    repeat (30) cycle(0, 100);
    for (int p = 0; p < NP; p++) chk(pend[p].size() == 0, "R9", pend[p].size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule